// File: doc/BRIEF.md
# HDLC Transmit Framer with Abort

This block turns a stream of payload bytes into a bit-synchronous HDLC line signal. Bytes arrive on a valid/ready port with a marker on the final byte of each frame. The framer sends one line bit each time the `bit_en` strobe is high. Each frame is sent as follows:

- an opening flag;
- the payload, least significant bit first;
- a 16-bit frame check sequence;
- a closing flag.

After five ones in a row inside the frame, the framer adds a zero so that the payload cannot look like a flag. Between frames the line carries either steady ones or back-to-back flags. The `idle_flags` pin picks which.

An abort can come from the `abort_req` pin or from an input underrun in the middle of a frame. In both cases the framer ends the frame and sends a run of ones: eight normally, or sixteen when `abort_ext` is set. A requested abort also pulses `flush`, so that the upstream byte buffer can be emptied.

Back-pressure rules:

- `in_ready` is high only in a cycle where `bit_en` is high and the framer needs its next byte.
- A byte moves when `in_valid` and `in_ready` are both high in the same cycle.
- Once a frame has started, the source must keep `in_valid` high until that frame's last byte has been accepted.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, `tx_bit` is 1, `flush` is 0 and `in_ready` is 0. `tx_bit` changes only in the cycle after a cycle with `bit_en` high.
- R2: While no frame is being sent and `idle_flags` is 0, every strobe sends 1. When `idle_flags` is 1, the line repeats the flag 8'h7E, LSB first, which is the bit sequence 0,1,1,1,1,1,1,0.
- R3: A frame starts only at a flag boundary and only when `in_valid` is high. It consists of a complete opening flag, the payload bytes LSB first, the FCS and one closing flag.
- R4: The FCS is a CRC-16. It uses the reflected polynomial 16'h8408, is preset to 16'hFFFF and runs over the payload bits. It is sent complemented, bit 0 first through bit 15, which puts the low byte first. Running the same CRC over the payload and the FCS together leaves 16'hF0B8.
- R5: In the payload and FCS, every run of five ones is followed by an added zero. Flags and abort runs are sent without added zeros.
- R6: `in_ready` is high only in a strobe cycle at a byte boundary: the last bit of the opening flag, or the last bit of a byte that is not the last of its frame. Each accepted byte is sent exactly once.
- R7: A cycle with `abort_req` high ends any frame. The next 8 strobes then send ones, and after that the line returns to idle.
- R8: If `abort_ext` is 1 when an abort starts, the run of ones is 16 bits long instead of 8.
- R9: `flush` is 1 in each cycle that follows a cycle with `abort_req` high. Otherwise it is 0.
- R10: If `in_valid` is low at a byte boundary inside a frame, the framer sends an abort of the same length as a requested one. `flush` stays 0.
- R11: After an abort ends, the next frame begins with a complete opening flag, and its content is correct.
- R12: In flag-idle mode, idle flags follow the closing flag directly, with no gap bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe: one line bit is sent per cycle in which this is high |
| idle_flags | input | 1 | Idle fill: 0 sends ones, 1 sends flags |
| abort_req | input | 1 | Abort request; it also starts a flush |
| abort_ext | input | 1 | Lengthens an abort from 8 to 16 ones |
| in_valid | input | 1 | A payload byte is offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | The offered byte is the last one of its frame |
| in_ready | output | 1 | The byte is taken in this cycle |
| flush | output | 1 | One-cycle request to empty the upstream buffer |
| tx_bit | output | 1 | Serial line bit |

## Verification
The hardest case to reach is an added zero that falls just before the closing flag or across a byte boundary. Here the ones counter has to carry from one part of the frame into the next. The stimulus uses all-ones payload bytes, which force runs of ones across every boundary, including into the FCS. The same stimulus exercises the abort paths: abort requests land between strobes in the middle of a frame, and the source withdraws `in_valid` at a byte boundary. Captured streams are compared bit by bit against a frame built from the requirements. The CRC residue is checked separately, on the captured bits after the added zeros are removed.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_CLOSE,
    ST_ABORT
  } tx_state_e;

  localparam logic [7:0]  FLAG_PAT     = 8'h7E;
  localparam logic [15:0] CRC_POLY_REF = 16'h8408;
  localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
endpackage

// File: rtl/hdlc_crc16.sv
module hdlc_crc16
  import hdlc_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic        din,
  output logic [15:0] crc
);
  logic fb;
  assign fb = crc[0] ^ din;

  always_ff @(posedge clk) begin
    if (!rst_n || init) crc <= CRC_PRESET;
    else if (upd)       crc <= (crc >> 1) ^ (fb ? CRC_POLY_REF : 16'h0000);
  end
endmodule

// File: rtl/hdlc_stuff_ctr.sv
module hdlc_stuff_ctr #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic strobe,
  input  logic payload,
  input  logic din,
  output logic need
);
  localparam int CW = $clog2(RUN + 1);
  logic [CW-1:0] cnt;

  assign need = (cnt == CW'(RUN));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (strobe) begin
      if (need)         cnt <= '0;
      else if (payload) cnt <= din ? cnt + CW'(1) : '0;
    end
  end

  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && need) |=> (cnt == '0));
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int ABORT_LEN     = 8,
  parameter int ABORT_EXT_LEN = 16,
  parameter int STUFF_RUN     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       idle_flags,
  input  logic       abort_req,
  input  logic       abort_ext,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       flush,
  output logic       tx_bit
);
  localparam int ACNT_W = $clog2(ABORT_EXT_LEN + 1);
  localparam logic [ACNT_W-1:0] LEN_NORM = ACNT_W'(ABORT_LEN);
  localparam logic [ACNT_W-1:0] LEN_EXT  = ACNT_W'(ABORT_EXT_LEN);

  tx_state_e         state;
  logic [3:0]        bcnt;
  logic [7:0]        shreg;
  logic              cur_last;
  logic              ext_q;
  logic [ACNT_W-1:0] acnt;
  logic [15:0]       crc;
  logic              need_stuff, stuff_state, stuff_now, load_pt, go;
  logic [ACNT_W-1:0] abort_len;

  assign go          = bit_en && !abort_req;
  assign stuff_state = (state == ST_DATA) || (state == ST_FCS) || (state == ST_CLOSE);
  assign stuff_now   = stuff_state && need_stuff;
  assign load_pt     = !stuff_now && bcnt == 4'd7 &&
                       ((state == ST_OPEN) || (state == ST_DATA && !cur_last));
  assign in_ready    = go && load_pt;
  assign abort_len   = ext_q ? LEN_EXT : LEN_NORM;

  hdlc_crc16 u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .init (state == ST_OPEN),
    .upd  (go && state == ST_DATA && !stuff_now),
    .din  (shreg[0]),
    .crc  (crc)
  );

  hdlc_stuff_ctr #(.RUN(STUFF_RUN)) u_stuff (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (!stuff_state),
    .strobe (go && stuff_state),
    .payload((state == ST_DATA) || (state == ST_FCS)),
    .din    ((state == ST_DATA) ? shreg[0] : ~crc[bcnt]),
    .need   (need_stuff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) flush <= 1'b0;
    else        flush <= abort_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bcnt     <= '0;
      shreg    <= '0;
      cur_last <= 1'b0;
      ext_q    <= 1'b0;
      acnt     <= '0;
      tx_bit   <= 1'b1;
    end else if (abort_req) begin
      state <= ST_ABORT;
      ext_q <= abort_ext;
      bcnt  <= '0;
      if (bit_en) begin
        tx_bit <= 1'b1;
        acnt   <= ACNT_W'(1);
      end else begin
        acnt <= '0;
      end
    end else if (bit_en) begin
      case (state)
        ST_IDLE: begin
          if (in_valid && bcnt == 4'd0) begin
            tx_bit <= FLAG_PAT[0];
            bcnt   <= 4'd1;
            state  <= ST_OPEN;
          end else if (idle_flags) begin
            tx_bit <= FLAG_PAT[bcnt[2:0]];
            bcnt   <= {1'b0, bcnt[2:0] + 3'd1};
          end else begin
            tx_bit <= 1'b1;
            bcnt   <= '0;
          end
        end
        ST_OPEN, ST_DATA: begin
          if (stuff_now) begin
            tx_bit <= 1'b0;
          end else begin
            tx_bit <= (state == ST_OPEN) ? FLAG_PAT[bcnt[2:0]] : shreg[0];
            shreg  <= shreg >> 1;
            if (bcnt == 4'd7) begin
              bcnt <= '0;
              if (state == ST_DATA && cur_last) begin
                state <= ST_FCS;
              end else if (in_valid) begin
                shreg    <= in_data;
                cur_last <= in_last;
                state    <= ST_DATA;
              end else begin
                state <= ST_ABORT;
                ext_q <= abort_ext;
                acnt  <= '0;
              end
            end else begin
              bcnt <= bcnt + 4'd1;
            end
          end
        end
        ST_FCS: begin
          if (stuff_now) tx_bit <= 1'b0;
          else begin
            tx_bit <= ~crc[bcnt];
            if (bcnt == 4'd15) begin
              state <= ST_CLOSE;
              bcnt  <= '0;
            end else bcnt <= bcnt + 4'd1;
          end
        end
        ST_CLOSE: begin
          if (stuff_now) tx_bit <= 1'b0;
          else begin
            tx_bit <= FLAG_PAT[bcnt[2:0]];
            if (bcnt == 4'd7) begin
              state <= ST_IDLE;
              bcnt  <= '0;
            end else bcnt <= bcnt + 4'd1;
          end
        end
        default: begin
          tx_bit <= 1'b1;
          if (acnt + ACNT_W'(1) >= abort_len) begin
            state <= ST_IDLE;
            bcnt  <= '0;
            acnt  <= '0;
          end else acnt <= acnt + ACNT_W'(1);
        end
      endcase
    end
  end

  assert_ready_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_en);
  assert_flush_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> flush);
  assert_line_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));
  assert_stuff_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && stuff_now) |=> !tx_bit);
  assert_abort_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && state == ST_ABORT) |=> tx_bit);
  assert_no_ready_in_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> !in_ready);
endmodule

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, idle_flags = 1'b0, abort_req = 1'b0, abort_ext = 1'b0;
  logic in_valid, in_last, in_ready, flush, tx_bit;
  logic [7:0] in_data;

  always #5 clk = ~clk;

  hdlc_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .idle_flags(idle_flags),
    .abort_req(abort_req), .abort_ext(abort_ext), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .flush(flush), .tx_bit(tx_bit)
  );

  int nchk = 0, nerr = 0;
  logic [7:0] src [16];
  int slen = 0, sidx = 0, stop_at = 16;
  bit src_on = 0;
  bit cap [1024];
  int ncap = 0;
  bit expb [512];
  int nexp = 0;
  int ready_cnt = 0, accepted = 0;
  bit flush_seen = 0;
  localparam logic [7:0] FLAG = 8'h7E;

  always @(posedge clk) if (flush) flush_seen <= 1'b1;

  function automatic void upd_src();
    in_valid = src_on && sidx < slen && sidx < stop_at;
    in_data  = src[sidx % 16];
    in_last  = (sidx == slen - 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit flags);
    rst_n = 0; bit_en = 0; abort_req = 0; abort_ext = 0; idle_flags = flags;
    src_on = 0; sidx = 0; stop_at = 16; ncap = 0; ready_cnt = 0; accepted = 0;
    upd_src();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; flush_seen = 0;
  endtask

  task automatic strobe(input int n);
    for (int k = 0; k < n; k++) begin
      bit take;
      @(negedge clk); bit_en = 1; #1;
      take = in_ready && in_valid;
      if (in_ready) ready_cnt++;
      @(posedge clk); #2;
      bit_en = 0;
      if (take) begin sidx++; accepted++; upd_src(); end
      cap[ncap] = tx_bit; ncap++;
    end
  endtask

  function automatic void push(bit b); expb[nexp] = b; nexp++; endfunction

  function automatic void build_exp();
    logic [15:0] c = 16'hFFFF;
    int ones = 0;
    nexp = 0;
    for (int i = 0; i < 8; i++) push(FLAG[i]);
    for (int j = 0; j < slen + 2; j++) begin
      for (int i = 0; i < 8; i++) begin
        bit b;
        if (j < slen) begin
          b = src[j][i];
        end else begin
          b = ~c[(j - slen) * 8 + i];
        end
        push(b);
        if (j < slen) begin
          bit fb = c[0] ^ b;
          c = c >> 1;
          if (fb) c = c ^ 16'h8408;
        end
        ones = b ? ones + 1 : 0;
        if (ones == 5) begin push(1'b0); ones = 0; end
      end
    end
    for (int i = 0; i < 8; i++) push(FLAG[i]);
  endfunction

  task automatic cmp_frame(input int start, input string req);
    int bad = -1;
    for (int i = 0; i < nexp; i++)
      if (bad < 0 && cap[start + i] != expb[i]) bad = i;
    check(bad < 0, req, bad, -1);
  endtask

  task automatic residue(input int start, input string req);
    logic [15:0] c = 16'hFFFF;
    int ones = 0, got = 0, i = start + 8;
    while (got < slen * 8 + 16 && i < ncap) begin
      bit b = cap[i];
      i++;
      if (ones == 5) begin
        ones = 0;
      end else begin
        bit fb = c[0] ^ b;
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
        ones = b ? ones + 1 : 0;
        got++;
      end
    end
    check(c == 16'hF0B8, req, c, 16'hF0B8);
  endtask

  task automatic pulse_abort(input bit ext);
    @(negedge clk); abort_req = 1; abort_ext = ext;
    @(posedge clk); #2;
    check(flush == 1'b1, "R9 flush after abort", flush, 1);
    @(negedge clk); abort_req = 0; src_on = 0; upd_src();
    @(posedge clk); #2;
    check(flush == 1'b0, "R9 flush single cycle", flush, 0);
  endtask

  task automatic t_reset();
    do_reset(0);
    check(tx_bit == 1 && flush == 0 && in_ready == 0, "R1 reset state",
          {tx_bit, flush, in_ready}, 3'b100);
    repeat (4) @(posedge clk); #2;
    check(tx_bit == 1, "R1 line holds without strobe", tx_bit, 1);
  endtask

  task automatic t_idle();
    int ones = 0, bad = 0;
    do_reset(0); strobe(16);
    for (int i = 0; i < 16; i++) ones += cap[i];
    check(ones == 16, "R2 mark idle ones", ones, 16);
    do_reset(1); strobe(24);
    for (int i = 0; i < 24; i++) if (cap[i] != FLAG[i % 8]) bad++;
    check(bad == 0, "R2 flag idle pattern", bad, 0);
  endtask

  task automatic t_frame(input bit flags, input string tag);
    int tail = 0;
    build_exp();
    src_on = 1; upd_src();
    strobe(nexp + 16);
    cmp_frame(0, {tag, " frame stream"});
    residue(0, "R4 crc residue");
    check(accepted == slen, "R6 bytes accepted", accepted, slen);
    check(ready_cnt == slen, "R6 ready pulses", ready_cnt, slen);
    for (int i = 0; i < 8; i++)
      if (cap[nexp + i] != (flags ? FLAG[i] : 1'b1)) tail++;
    check(tail == 0, flags ? "R12 flags after close" : "R3 ones after close", tail, 0);
  endtask

  task automatic t_basic();
    do_reset(0);
    slen = 3; src[0] = 8'hA5; src[1] = 8'h3C; src[2] = 8'h81;
    t_frame(0, "R3");
  endtask

  task automatic t_stuff();
    do_reset(0);
    slen = 4; src[0] = 8'hFF; src[1] = 8'hFF; src[2] = 8'h7E; src[3] = 8'hF8;
    t_frame(0, "R5");
    check(nexp > 8 + 48 + 8, "R5 zeros were inserted", nexp, 65);
  endtask

  task automatic t_timefill();
    do_reset(1);
    slen = 1; src[0] = 8'h12;
    t_frame(1, "R12");
  endtask

  task automatic t_abort(input bit ext);
    int m, ones = 0, len;
    len = ext ? 16 : 8;
    do_reset(1);
    slen = 4; for (int i = 0; i < 4; i++) src[i] = 8'h00;
    src_on = 1; upd_src();
    strobe(12);
    pulse_abort(ext);
    ready_cnt = 0; m = ncap;
    strobe(len + 2);
    for (int i = 0; i < len; i++) ones += cap[m + i];
    check(ones == len, ext ? "R8 extended abort ones" : "R7 abort ones", ones, len);
    check(cap[m + len] == 0, ext ? "R8 abort length" : "R7 abort then idle", cap[m + len], 0);
    check(ready_cnt == 0, "R7 no bytes taken after abort", ready_cnt, 0);
  endtask

  task automatic t_underrun();
    int ones = 0, zeros = 0;
    do_reset(1);
    slen = 3; for (int i = 0; i < 3; i++) src[i] = 8'h00;
    stop_at = 1; src_on = 1; upd_src();
    strobe(26);
    for (int i = 8; i < 16; i++) zeros += !cap[i];
    for (int i = 16; i < 24; i++) ones += cap[i];
    check(zeros == 8 && ones == 8 && cap[24] == 0, "R10 underrun abort", ones, 8);
    check(flush_seen == 0, "R10 no flush on underrun", flush_seen, 0);
  endtask

  task automatic t_after_abort();
    int m;
    do_reset(0);
    slen = 2; src[0] = 8'h00; src[1] = 8'h00;
    src_on = 1; upd_src();
    strobe(10);
    pulse_abort(0);
    strobe(12);
    slen = 2; src[0] = 8'hC3; src[1] = 8'h55; sidx = 0; stop_at = 16;
    build_exp();
    src_on = 1; upd_src();
    m = ncap;
    strobe(nexp + 4);
    cmp_frame(m, "R11 frame after abort");
    residue(m, "R11 crc after abort");
  endtask

  initial begin
    #2_000_000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    upd_src();
    t_reset();
    t_idle();
    t_basic();
    t_stuff();
    t_timefill();
    t_abort(0);
    t_abort(1);
    t_underrun();
    t_after_abort();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule